// File: doc/BRIEF.md
# Page Access Permission Gate

This block makes the permission decision for one memory access once a translation lookup has already produced the page entry. Each request carries four attribute bits from that entry: present, user-accessible, writable and no-execute. It also carries the current privilege level of the running code and the kind of access: data read, data write or instruction fetch. One clock cycle later the block answers with a response strobe. The answer is either an allow or a fault, and a fault comes with a 2-bit cause code.

The user-accessible attribute is a single bit. When it is 0 the page is reserved for privileged code; when it is 1 any level may use it. The privilege level is two bits wide, and only its highest value (3) counts as unprivileged. Levels 0, 1 and 2 pass the privilege check on every page. After the privilege check, writes must find the writable bit set and fetches must find the no-execute bit clear. A read needs nothing more.

Control is a two-state machine. In `ST_IDLE` no answer is being presented. In `ST_RESP` a registered answer is on the outputs. The transition `T_ACCEPT` (IDLE to RESP) fires on a request strobe. `T_CHAIN` (RESP to RESP) fires on a request that directly follows another. `T_DRAIN` (RESP to IDLE) fires when no request arrives, and `T_WAIT` (IDLE to IDLE) holds the machine otherwise.

Top module: `pgperm_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_vld`, `rsp_ok`, `rsp_fault` and `rsp_cause` are all 0.
- R2: `rsp_vld` is 1 in exactly those cycles whose preceding clock edge sampled `req_vld` high. Back-to-back requests yield back-to-back responses, each carrying the verdict for its own request.
- R3: When `rsp_vld` is 0, `rsp_ok`, `rsp_fault` and `rsp_cause` are 0, whatever the other inputs are doing.
- R4: A request with `pte_present`=0 faults with cause 0 (not present), whatever the other inputs.
- R5: A request with `cpl`=3 to a present page with `pte_user`=0 faults with cause 1 (privilege).
- R6: Privilege levels 0, 1 and 2 pass the privilege check on pages with either value of `pte_user`.
- R7: A write (`acc_kind`=01) that passes the earlier checks faults with cause 2 (write protect) when `pte_wr`=0.
- R8: A fetch (`acc_kind`=10) that passes the earlier checks faults with cause 3 (no execute) when `pte_nx`=1.
- R9: A read (`acc_kind`=00, and also the spare code 11, which is handled as a read) is allowed on any present page that passes the privilege check, whatever `pte_wr` and `pte_nx` hold.
- R10: When several checks fail at once, the cause is the first failure in the order not-present, privilege, write protect, no execute.
- R11: During a response exactly one of `rsp_ok` and `rsp_fault` is 1, and `rsp_cause` is 0 when `rsp_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe, one request per cycle it is high |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 handled as read |
| cpl | input | CPL_W | Current privilege level, highest value unprivileged |
| pte_present | input | 1 | Page entry valid |
| pte_user | input | 1 | 1: page usable by unprivileged code |
| pte_wr | input | 1 | 1: page writable |
| pte_nx | input | 1 | 1: fetch forbidden |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 not present, 1 privilege, 2 write protect, 3 no execute |

## Verification
The decision is swept over all 256 combinations of access kind, privilege level and the four attribute bits. Each combination is compared with a priority model, so every ordering conflict between checks is resolved at least once. Directed patterns separate the privilege rule from the attribute rules: a supervisor page is read at each level, and a read is made with write protection and no-execute both set. They also show that the spare kind code behaves as a read. Timing patterns cover a lone request followed by silence and a chain of back-to-back requests with alternating verdicts. These show whether the strobe tracks the request and whether each answer belongs to its own request. A run of attribute changes with the strobe low confirms that the outputs stay quiet.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CZ_ABSENT = 2'd0,
        CZ_PRIV   = 2'd1,
        CZ_WPROT  = 2'd2,
        CZ_NOEXEC = 2'd3
    } cause_e;

    typedef struct packed {
        logic present;
        logic user;
        logic wr;
        logic nx;
    } pte_attr_t;

    typedef struct packed {
        logic   ok;
        cause_e cause;
    } verdict_t;

endpackage

// File: rtl/pgperm_rules.sv
module pgperm_rules
    import pgperm_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  acc_kind_e          kind,
    input  logic [CPL_W-1:0]   cpl,
    input  pte_attr_t          attr,
    output verdict_t           verdict
);
    localparam logic [CPL_W-1:0] UNPRIV_LVL = {CPL_W{1'b1}};

    logic priv_bad;
    logic wr_bad;
    logic ex_bad;

    assign priv_bad = (cpl == UNPRIV_LVL) && !attr.user;
    assign wr_bad   = (kind == ACC_WRITE) && !attr.wr;
    assign ex_bad   = (kind == ACC_FETCH) && attr.nx;

    // fixed priority: absent, privilege, write protect, no execute
    always_comb begin
        verdict.ok    = 1'b0;
        verdict.cause = CZ_ABSENT;
        if (!attr.present) begin
            verdict.cause = CZ_ABSENT;
        end else if (priv_bad) begin
            verdict.cause = CZ_PRIV;
        end else if (wr_bad) begin
            verdict.cause = CZ_WPROT;
        end else if (ex_bad) begin
            verdict.cause = CZ_NOEXEC;
        end else begin
            verdict.ok = 1'b1;
        end
    end
endmodule

// File: rtl/pgperm_fsm.sv
module pgperm_fsm
    import pgperm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_vld,
    input  verdict_t  verdict,
    output logic      rsp_vld,
    output logic      rsp_ok,
    output logic      rsp_fault,
    output logic [1:0] rsp_cause
);
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;

    st_e state;
    st_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = req_vld ? ST_RESP : ST_IDLE; // T_ACCEPT / T_WAIT
            ST_RESP: state_nx = req_vld ? ST_RESP : ST_IDLE; // T_CHAIN / T_DRAIN
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !req_vld) begin
            rsp_ok    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= 2'd0;
        end else begin
            rsp_ok    <= verdict.ok;
            rsp_fault <= !verdict.ok;
            rsp_cause <= verdict.ok ? 2'd0 : verdict.cause;
        end
    end

    assign rsp_vld = (state == ST_RESP);
endmodule

// File: rtl/pgperm_gate.sv
module pgperm_gate
    import pgperm_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [1:0]       acc_kind,
    input  logic [CPL_W-1:0] cpl,
    input  logic             pte_present,
    input  logic             pte_user,
    input  logic             pte_wr,
    input  logic             pte_nx,
    output logic             rsp_vld,
    output logic             rsp_ok,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause
);
    pte_attr_t attr;
    verdict_t  verdict;

    assign attr = '{present: pte_present, user: pte_user, wr: pte_wr, nx: pte_nx};

    pgperm_rules #(.CPL_W(CPL_W)) u_rules (
        .kind    (acc_kind_e'(acc_kind)),
        .cpl     (cpl),
        .attr    (attr),
        .verdict (verdict)
    );

    pgperm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .verdict   (verdict),
        .rsp_vld   (rsp_vld),
        .rsp_ok    (rsp_ok),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause)
    );
endmodule

// File: rtl/pgperm_chk.sv
module pgperm_chk #(
    parameter int CPL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic [1:0]       acc_kind,
    input logic [CPL_W-1:0] cpl,
    input logic             pte_present,
    input logic             pte_user,
    input logic             pte_wr,
    input logic             pte_nx,
    input logic             rsp_vld,
    input logic             rsp_ok,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause
);
    localparam logic [CPL_W-1:0] TOP_LVL = {CPL_W{1'b1}};

    p_req_gets_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    p_no_req_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_ok && !rsp_fault && rsp_cause == 2'd0));

    p_absent_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !pte_present) |=> (rsp_fault && rsp_cause == 2'd0));

    p_user_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && pte_present && cpl == TOP_LVL && !pte_user)
            |=> (rsp_fault && rsp_cause == 2'd1));

    p_read_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && pte_present && (pte_user || cpl != TOP_LVL) &&
         (acc_kind == 2'd0 || acc_kind == 2'd3)) |=> rsp_ok);

    p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $onehot({rsp_ok, rsp_fault}));

    p_ok_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> rsp_cause == 2'd0);

    // unused in properties beyond decoding; keep referenced
    logic unused_ok;
    assign unused_ok = pte_wr ^ pte_nx;
endmodule

bind pgperm_gate pgperm_chk #(.CPL_W(CPL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .acc_kind    (acc_kind),
    .cpl         (cpl),
    .pte_present (pte_present),
    .pte_user    (pte_user),
    .pte_wr      (pte_wr),
    .pte_nx      (pte_nx),
    .rsp_vld     (rsp_vld),
    .rsp_ok      (rsp_ok),
    .rsp_fault   (rsp_fault),
    .rsp_cause   (rsp_cause)
);

// File: tb/sim_pgperm_gate.sv
`timescale 1ns/1ps
module sim_pgperm_gate;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_vld;
    logic [1:0] acc_kind;
    logic [1:0] cpl;
    logic       pte_present, pte_user, pte_wr, pte_nx;
    logic       rsp_vld, rsp_ok, rsp_fault;
    logic [1:0] rsp_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pgperm_gate u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .acc_kind(acc_kind),
        .cpl(cpl), .pte_present(pte_present), .pte_user(pte_user),
        .pte_wr(pte_wr), .pte_nx(pte_nx), .rsp_vld(rsp_vld), .rsp_ok(rsp_ok),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    // model: {ok, cause}
    function automatic logic [2:0] model(input logic [1:0] k, input logic [1:0] l,
                                          input logic p, input logic u,
                                          input logic w, input logic x);
        if (!p)                  return 3'b0_00;
        if (l == 2'd3 && !u)     return 3'b0_01;
        if (k == 2'd1 && !w)     return 3'b0_10;
        if (k == 2'd2 && x)      return 3'b0_11;
        return 3'b1_00;
    endfunction

    task automatic chk(input string tag, input logic v, input logic ok, input logic [1:0] cz);
        logic fl;
        fl = v && !ok;
        n_chk++;
        if (rsp_vld !== v || rsp_ok !== ok || rsp_fault !== fl || rsp_cause !== cz) begin
            n_fail++;
            $display("FAIL %s: got vld=%b ok=%b fault=%b cause=%0d, expected vld=%b ok=%b fault=%b cause=%0d",
                     tag, rsp_vld, rsp_ok, rsp_fault, rsp_cause, v, ok, fl, cz);
        end
    endtask

    task automatic drive(input logic r, input logic [1:0] k, input logic [1:0] l,
                         input logic p, input logic u, input logic w, input logic x);
        req_vld = r; acc_kind = k; cpl = l;
        pte_present = p; pte_user = u; pte_wr = w; pte_nx = x;
    endtask

    // single request, then idle; checks response one cycle later
    task automatic one_req(input string tag, input logic [1:0] k, input logic [1:0] l,
                           input logic p, input logic u, input logic w, input logic x);
        logic [2:0] e;
        e = model(k, l, p, u, w, x);
        drive(1'b1, k, l, p, u, w, x);
        @(negedge clk);
        req_vld = 1'b0;
        chk(tag, 1'b1, e[2], e[1:0]);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive(1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 1'b0, 2'd0);
        req_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 1'b0, 2'd0);
    endtask

    task automatic t_quiet;
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, 2'(i), 2'(i), i[0], i[1], i[2], ~i[0]);
            @(negedge clk);
            chk("R3 no request", 1'b0, 1'b0, 2'd0);
        end
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 256; i++) begin
            logic [1:0] k, l;
            logic p, u, w, x;
            logic [2:0] e;
            string tag;
            k = i[7:6]; l = i[5:4]; p = i[3]; u = i[2]; w = i[1]; x = i[0];
            e = model(k, l, p, u, w, x);
            if (e[2])            tag = "R9/R6 sweep allow";
            else if (e[1:0] == 0) tag = "R4 sweep absent";
            else if (e[1:0] == 1) tag = "R5 sweep privilege";
            else if (e[1:0] == 2) tag = "R7 sweep write protect";
            else                  tag = "R8 sweep no execute";
            one_req(tag, k, l, p, u, w, x);
        end
    endtask

    task automatic t_levels;
        for (int l = 0; l < 3; l++) begin
            one_req("R6 supervisor page read", 2'd0, 2'(l), 1'b1, 1'b0, 1'b0, 1'b0);
            one_req("R6 user page fetch", 2'd2, 2'(l), 1'b1, 1'b1, 1'b0, 1'b0);
        end
        one_req("R5 level 3 supervisor read", 2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reads;
        one_req("R9 read ignores wr/nx", 2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        one_req("R9 spare kind as read", 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        one_req("R7 write protected", 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        one_req("R8 fetch no execute", 2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_priority;
        one_req("R10 absent beats all", 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        one_req("R10 privilege beats write", 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        one_req("R10 privilege beats nx", 2'd2, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1);
        one_req("R11 allowed write cause 0", 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_chain;
        logic [2:0] e;
        // alternating verdicts, strobe held high
        for (int i = 0; i < 6; i++) begin
            logic p, w;
            p = (i % 3) != 0;
            w = i[0];
            if (i > 0) begin
                e = model(2'd1, 2'd2, (((i-1) % 3) != 0), 1'b1, 1'(i-1), 1'b0);
                drive(1'b1, 2'd1, 2'd2, p, 1'b1, w, 1'b0);
                chk("R2 chained response", 1'b1, e[2], e[1:0]);
            end else begin
                drive(1'b1, 2'd1, 2'd2, p, 1'b1, w, 1'b0);
            end
            @(negedge clk);
        end
        e = model(2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);
        req_vld = 1'b0;
        chk("R2 last of chain", 1'b1, e[2], e[1:0]);
        @(negedge clk);
        chk("R2 strobe drops", 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        chk("R3 stays quiet", 1'b0, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset;
        t_quiet;
        t_sweep;
        t_levels;
        t_reads;
        t_priority;
        t_chain;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule